// File: doc/BRIEF.md
# Dual-CPU Shared Memory Control Port

This block is the register port of one CPU on a two-CPU arcade board. It latches the control byte the game writes to the controller register ($4016). Bit 0 is the joystick strobe. Bit 1 does two jobs: it drives the interrupt request line into the other CPU, and it decides which CPU owns a 2 KiB shared RAM. Bit 2 selects a graphics bank and, in the 40 KiB program configuration, an 8 KiB program bank.

For the shared RAM, the block gates access to the window at $6000-$7FFF. The window shows the RAM four times over. A CPU that does not own the RAM gets no chip select and sees an undriven bus.

On reads, the block assembles two bytes: a player, coin, service and DIP byte at $4016, and a second player and DIP byte at $4017. Each read also pulses the clock of the matching joystick shift register. The player ports are swapped relative to a home console: the right-hand player appears at $4016 and the left-hand player at $4017.

The same module serves either CPU socket. A strap input tells it which socket it sits in. An ownership input carries the board-level grant line, which the primary socket's port drives.

Top module: `dual_cpu_port`

## Requirements
- R1: On reset all latched control bits clear to 0. As a result the strobe, graphics bank, program bank and grant outputs read 0, and `peer_irq_n_o` reads 0, so the other CPU's IRQ is asserted.
- R2: A write to address 16'h4016 latches data bits 0 (strobe), 1 (share) and 2 (bank) at the next clock edge. Writes to any other address, and data bits 7-3, leave all outputs unchanged.
- R3: `peer_irq_n_o` carries latched bit 1, active low: it is 0 (other CPU's IRQ asserted) whenever bit 1 is 0.
- R4: `grant_o` carries latched bit 1 (1 means the primary CPU owns the RAM). This CPU may use the window when `owner_i` is 1 on the primary socket (`socket_sec_i`=0), or when `owner_i` is 0 on the secondary socket.
- R5: `chr_bank_o` carries latched bit 2. `prg_bank_o` carries it too when parameter PRG_40K is 1, and is 0 otherwise.
- R6: A read of 16'h4016 returns: bit 7 `socket_sec_i`, bit 6 `coin_i[1]`, bit 5 `coin_i[0]`, bit 4 `dip_i[1]` (switch 2), bit 3 `dip_i[0]` (switch 1), bit 2 `service_i`, bit 1 constant 0, bit 0 `pad_right_i`. The two coin bits are reported independently.
- R7: A read of 16'h4017 returns `dip_i[7:2]` (switches 8 down to 3) in bits 7-2, 0 in bit 1, and `pad_left_i` in bit 0.
- R8: `port_rdata_o` and `port_valid_o` are registered. `port_valid_o` is 1 for exactly the cycle after a read of either port, and the data holds until the next port read.
- R9: A read of 16'h4016 pulses `pad_right_clk_o` for one cycle, and a read of 16'h4017 pulses `pad_left_clk_o`, in the same cycle as `port_valid_o`.
- R10: While this CPU may use the window (R4), a read or write to 16'h6000-16'h7FFF raises `ram_cs_o` in the same cycle. `ram_we_o` equals the write strobe, and `ram_addr_o` is address bits 10:0. Addresses outside the window never raise `ram_cs_o`.
- R11: A window read by a CPU that may not use the RAM leaves `ram_cs_o` at 0 and raises `open_bus_o` for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | 16 | CPU address |
| bus_rd_i | input | 1 | Read cycle strobe |
| bus_wr_i | input | 1 | Write cycle strobe |
| bus_wdata_i | input | 8 | Write data |
| socket_sec_i | input | 1 | Strap: 1 when fitted in the secondary socket |
| owner_i | input | 1 | Board ownership line, 1 = primary owns shared RAM |
| pad_left_i | input | 1 | Left player serial data |
| pad_right_i | input | 1 | Right player serial data |
| coin_i | input | 2 | Coin acceptor switches |
| service_i | input | 1 | Service button |
| dip_i | input | 8 | DIP switches 1..8 at indices 0..7 |
| pad_strobe_o | output | 1 | Joystick latch strobe |
| pad_left_clk_o | output | 1 | Left pad shift clock pulse |
| pad_right_clk_o | output | 1 | Right pad shift clock pulse |
| peer_irq_n_o | output | 1 | Active-low IRQ to the other CPU |
| grant_o | output | 1 | Ownership drive, 1 = primary owns RAM |
| chr_bank_o | output | 1 | Graphics ROM 8 KiB bank select |
| prg_bank_o | output | 1 | Program ROM 8 KiB bank select at $8000 |
| port_rdata_o | output | 8 | Assembled port read byte |
| port_valid_o | output | 1 | Port read byte valid |
| ram_cs_o | output | 1 | Shared RAM chip select |
| ram_we_o | output | 1 | Shared RAM write enable |
| ram_addr_o | output | 11 | Shared RAM address |
| open_bus_o | output | 1 | Window read left undriven |

## Verification
An ownership change on `owner_i` can arrive in the same cycle that this CPU starts a window access. The decision must then follow the new owner at once, with no stale latched grant. The bench provokes this by flipping `owner_i` on the secondary socket at the same clock edge on which a window read is applied. It then requires `ram_cs_o` low during that cycle and `open_bus_o` high in the next. A second overlap comes from a `$4016` write that drops the share bit. The bench follows it with a window access in the next cycle and a check of the IRQ output, so the IRQ polarity and the ownership are judged together.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  localparam int DATA_W  = 8;
  localparam int DIP_N   = 8;
  localparam int COIN_N  = 2;
  localparam int BIT_STB = 0;
  localparam int BIT_SHR = 1;
  localparam int BIT_BNK = 2;

  typedef struct packed {
    logic bank;
    logic share;
    logic strobe;
  } ctl_t;
endpackage

// File: rtl/dcp_ctl_regs.sv
module dcp_ctl_regs
  import dcp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h4016
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output ctl_t              ctl
);
  logic hit;
  logic unused_hi;

  assign hit       = wr && (addr == PORT_ADDR);
  assign unused_hi = ^wdata[DATA_W-1:BIT_BNK+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else if (hit) begin
      ctl.strobe <= wdata[BIT_STB];
      ctl.share  <= wdata[BIT_SHR];
      ctl.bank   <= wdata[BIT_BNK];
    end
  end

  assert_share_latch_R3: assert property (@(posedge clk) disable iff (rst)
    hit |=> (ctl.share == $past(wdata[BIT_SHR])));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(ctl));
endmodule

// File: rtl/dcp_read_mux.sv
module dcp_read_mux
  import dcp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_R = 16'h4016,
  parameter logic [ADDR_W-1:0] PORT_L = 16'h4017
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              socket_sec,
  input  logic              pad_left,
  input  logic              pad_right,
  input  logic [COIN_N-1:0] coin,
  input  logic              service,
  input  logic [DIP_N-1:0]  dip,
  output logic [DATA_W-1:0] rdata,
  output logic              valid,
  output logic              clk_l,
  output logic              clk_r
);
  localparam int HI_DIPS = DIP_N - 2;

  logic              hit_r, hit_l;
  logic [DATA_W-1:0] byte_r, byte_l;

  assign hit_r = rd && (addr == PORT_R);
  assign hit_l = rd && (addr == PORT_L);

  // right player byte: socket, coins, low switches, service, zero, data
  always_comb begin
    byte_r    = '0;
    byte_r[7] = socket_sec;
    byte_r[6] = coin[1];
    byte_r[5] = coin[0];
    byte_r[4] = dip[1];
    byte_r[3] = dip[0];
    byte_r[2] = service;
    byte_r[1] = 1'b0;
    byte_r[0] = pad_right;
  end

  // left player byte: upper switches descend from bit 7
  always_comb begin
    byte_l    = '0;
    byte_l[1] = 1'b0;
    byte_l[0] = pad_left;
    for (int i = 0; i < HI_DIPS; i++) begin
      byte_l[2+i] = dip[2+i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      valid <= 1'b0;
      clk_l <= 1'b0;
      clk_r <= 1'b0;
    end else begin
      valid <= hit_r || hit_l;
      clk_r <= hit_r;
      clk_l <= hit_l;
      if (hit_r)      rdata <= byte_r;
      else if (hit_l) rdata <= byte_l;
    end
  end

  assert_zero_bit_R6: assert property (@(posedge clk) disable iff (rst)
    valid |-> (rdata[1] == 1'b0));

  assert_valid_after_read_R8: assert property (@(posedge clk) disable iff (rst)
    (hit_r || hit_l) |=> valid);

  assert_one_clock_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clk_l, clk_r}));

  assert_clock_with_valid_R9: assert property (@(posedge clk) disable iff (rst)
    (clk_l || clk_r) |-> valid);
endmodule

// File: rtl/dcp_ram_gate.sv
module dcp_ram_gate #(
  parameter int ADDR_W = 16,
  parameter int WIN_AW = 13,
  parameter int RAM_AW = 11,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h6000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              socket_sec,
  input  logic              owner,
  output logic              cs,
  output logic              we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              open_bus
);
  localparam int TAG_W = ADDR_W - WIN_AW;

  logic in_win, access;

  assign in_win   = (addr[ADDR_W-1:WIN_AW] == WIN_BASE[ADDR_W-1:WIN_AW]);
  assign access   = socket_sec ? !owner : owner;
  assign cs       = in_win && access && (rd || wr);
  assign we       = cs && wr;
  assign ram_addr = addr[RAM_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) open_bus <= 1'b0;
    else     open_bus <= rd && in_win && !access;
  end

  assert_cs_in_window_R10: assert property (@(posedge clk) disable iff (rst)
    cs |-> (addr[ADDR_W-1:WIN_AW] == TAG_W'(WIN_BASE >> WIN_AW)));

  assert_float_R11: assert property (@(posedge clk) disable iff (rst)
    (rd && in_win && !access) |=> open_bus);

  assert_no_cs_float_R11: assert property (@(posedge clk) disable iff (rst)
    open_bus |-> $past(!cs));
endmodule

// File: rtl/dual_cpu_port.sv
module dual_cpu_port
  import dcp_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int WIN_AW  = 13,
  parameter int RAM_AW  = 11,
  parameter bit PRG_40K = 1'b1,
  parameter logic [ADDR_W-1:0] PORT_R   = 16'h4016,
  parameter logic [ADDR_W-1:0] PORT_L   = 16'h4017,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h6000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              socket_sec_i,
  input  logic              owner_i,
  input  logic              pad_left_i,
  input  logic              pad_right_i,
  input  logic [COIN_N-1:0] coin_i,
  input  logic              service_i,
  input  logic [DIP_N-1:0]  dip_i,
  output logic              pad_strobe_o,
  output logic              pad_left_clk_o,
  output logic              pad_right_clk_o,
  output logic              peer_irq_n_o,
  output logic              grant_o,
  output logic              chr_bank_o,
  output logic              prg_bank_o,
  output logic [DATA_W-1:0] port_rdata_o,
  output logic              port_valid_o,
  output logic              ram_cs_o,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              open_bus_o
);
  ctl_t ctl;

  dcp_ctl_regs #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_R)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr_i), .wr(bus_wr_i),
    .wdata(bus_wdata_i), .ctl(ctl)
  );

  dcp_read_mux #(.ADDR_W(ADDR_W), .PORT_R(PORT_R), .PORT_L(PORT_L)) u_rd (
    .clk(clk), .rst(rst), .addr(bus_addr_i), .rd(bus_rd_i),
    .socket_sec(socket_sec_i), .pad_left(pad_left_i), .pad_right(pad_right_i),
    .coin(coin_i), .service(service_i), .dip(dip_i),
    .rdata(port_rdata_o), .valid(port_valid_o),
    .clk_l(pad_left_clk_o), .clk_r(pad_right_clk_o)
  );

  dcp_ram_gate #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .RAM_AW(RAM_AW),
                 .WIN_BASE(WIN_BASE)) u_gate (
    .clk(clk), .rst(rst), .addr(bus_addr_i), .rd(bus_rd_i), .wr(bus_wr_i),
    .socket_sec(socket_sec_i), .owner(owner_i),
    .cs(ram_cs_o), .we(ram_we_o), .ram_addr(ram_addr_o), .open_bus(open_bus_o)
  );

  assign pad_strobe_o = ctl.strobe;
  assign peer_irq_n_o = ctl.share;
  assign grant_o      = ctl.share;
  assign chr_bank_o   = ctl.bank;

  generate
    if (PRG_40K) begin : g_prg_switch
      assign prg_bank_o = ctl.bank;
    end else begin : g_prg_fixed
      assign prg_bank_o = 1'b0;
    end
  endgenerate

  assert_irq_with_grant_R3: assert property (@(posedge clk) disable iff (rst)
    (peer_irq_n_o == grant_o));

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!peer_irq_n_o && !pad_strobe_o && !chr_bank_o));
endmodule

// File: tb/dual_cpu_port_bench.sv
module dual_cpu_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic        sock = 1'b0, owner = 1'b0;
  logic        padl = 1'b0, padr = 1'b0;
  logic [1:0]  coin = '0;
  logic        svc = 1'b0;
  logic [7:0]  dip = '0;
  logic        strobe, lclk, rclk, irq_n, grant, chr, prg;
  logic [7:0]  rdata;
  logic        valid, cs, we, obus;
  logic [10:0] raddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dual_cpu_port u_dual_cpu_port (
    .clk(clk), .rst(rst), .bus_addr_i(addr), .bus_rd_i(rd), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .socket_sec_i(sock), .owner_i(owner),
    .pad_left_i(padl), .pad_right_i(padr), .coin_i(coin), .service_i(svc),
    .dip_i(dip), .pad_strobe_o(strobe), .pad_left_clk_o(lclk),
    .pad_right_clk_o(rclk), .peer_irq_n_o(irq_n), .grant_o(grant),
    .chr_bank_o(chr), .prg_bank_o(prg), .port_rdata_o(rdata),
    .port_valid_o(valid), .ram_cs_o(cs), .ram_we_o(we), .ram_addr_o(raddr),
    .open_bus_o(obus)
  );

  // {sock, coin[1:0], svc, dip[7:0], padl, padr, port(0=$4016,1=$4017), expected}
  localparam logic [22:0] VEC [8] = '{
    {1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h01},
    {1'b1, 2'b01, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'hA0},
    {1'b0, 2'b10, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h44},
    {1'b0, 2'b11, 1'b0, 8'h03, 1'b0, 1'b1, 1'b0, 8'h79},
    {1'b0, 2'b00, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0, 8'h08},
    {1'b1, 2'b11, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b1, 8'hFD},
    {1'b0, 2'b00, 1'b0, 8'h84, 1'b0, 1'b0, 1'b1, 8'h84},
    {1'b0, 2'b00, 1'b1, 8'h03, 1'b1, 1'b0, 1'b1, 8'h01}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at negedge; registered results are sampled 1 ns after the next edge
  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic ctl_expect(input bit s, input bit i, input bit b, input string tag);
    chk(strobe == s, {tag, " strobe"}, strobe, s);
    chk(irq_n == i && grant == i, {tag, " share"}, irq_n, i);
    chk(chr == b && prg == b, {tag, " bank"}, chr, b);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: everything clear, other CPU's IRQ held asserted
    ctl_expect(1'b0, 1'b0, 1'b0, "R1 reset");
    chk(valid == 1'b0 && obus == 1'b0, "R1 status", valid, 0);

    bus_write(16'h4016, 8'h07);
    ctl_expect(1'b1, 1'b1, 1'b1, "R2 latch 07");
    chk(prg == 1'b1, "R5 prg bank", prg, 1);
    bus_write(16'h4016, 8'h06);
    ctl_expect(1'b0, 1'b1, 1'b1, "R2 strobe fall");
    bus_write(16'h4017, 8'h00);
    ctl_expect(1'b0, 1'b1, 1'b1, "R2 other addr ignored");
    bus_write(16'h4016, 8'hF8);
    ctl_expect(1'b0, 1'b0, 1'b0, "R2 high bits ignored");
    chk(irq_n == 1'b0, "R3 irq asserted low", irq_n, 0);
    bus_write(16'h4016, 8'h02);
    ctl_expect(1'b0, 1'b1, 1'b0, "R3 irq released");

    // R6 R7 R8 R9: table of read bytes
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      sock = VEC[k][22]; coin = VEC[k][21:20]; svc = VEC[k][19];
      dip = VEC[k][18:11]; padl = VEC[k][10]; padr = VEC[k][9];
      addr = VEC[k][8] ? 16'h4017 : 16'h4016; rd = 1'b1;
      @(posedge clk); #1;
      rd = 1'b0;
      chk(rdata == VEC[k][7:0], VEC[k][8] ? "R7 byte" : "R6 byte", rdata, VEC[k][7:0]);
      chk(valid == 1'b1, "R8 valid", valid, 1);
      chk(lclk == VEC[k][8] && rclk == !VEC[k][8], "R9 pad clock", {lclk, rclk}, {VEC[k][8], !VEC[k][8]});
    end
    @(posedge clk); #1;
    chk(valid == 1'b0 && lclk == 1'b0 && rclk == 1'b0, "R8 valid drops", valid, 0);
    chk(rdata == 8'h01, "R8 data holds", rdata, 8'h01);

    // R4 R10: primary owns when owner line high
    @(negedge clk); sock = 1'b0; owner = 1'b1; addr = 16'h6123; rd = 1'b1;
    #1 chk(cs == 1'b1 && we == 1'b0 && raddr == 11'h123, "R10 owned read", {cs, we, raddr}, {2'b10, 11'h123});
    @(negedge clk); rd = 1'b0; wr = 1'b1; addr = 16'h7FFF;
    #1 chk(cs == 1'b1 && we == 1'b1 && raddr == 11'h7FF, "R10 mirror write", {cs, we, raddr}, {2'b11, 11'h7FF});
    chk(obus == 1'b0, "R11 owned no float", obus, 0);
    @(negedge clk); wr = 1'b0; rd = 1'b1; addr = 16'h5FFF;
    #1 chk(cs == 1'b0, "R10 outside window", cs, 0);
    // R11: primary without ownership
    @(negedge clk); owner = 1'b0; addr = 16'h6800;
    #1 chk(cs == 1'b0, "R4 primary not owner", cs, 0);
    @(posedge clk); #1;
    chk(obus == 1'b1, "R11 open bus", obus, 1);
    // R4: secondary owns when line low
    @(negedge clk); sock = 1'b1; owner = 1'b0; addr = 16'h6005;
    #1 chk(cs == 1'b1 && raddr == 11'h005, "R4 secondary owner", cs, 1);
    @(posedge clk); #1;
    chk(obus == 1'b0, "R11 no float when owned", obus, 0);
    // owner flips in the same cycle as the window read
    @(negedge clk); owner = 1'b1; addr = 16'h6006;
    #1 chk(cs == 1'b0, "R4 flip same cycle", cs, 0);
    @(posedge clk); #1;
    chk(obus == 1'b1, "R11 flip floats", obus, 1);
    @(negedge clk); rd = 1'b0;
    // share bit drop followed at once by window access on the primary
    bus_write(16'h4016, 8'h00);
    chk(irq_n == 1'b0 && grant == 1'b0, "R3 drop share", irq_n, 0);
    @(negedge clk); sock = 1'b0; owner = grant; addr = 16'h6001; rd = 1'b1;
    #1 chk(cs == 1'b0, "R4 grant follows share", cs, 0);
    @(negedge clk); rd = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule